// File: doc/BRIEF.md
# Pad Boundary Scan Chain

This block is a serial chain of boundary scan cells placed between the peripheral cores of a chip and its I/O pads. Each pad is given one of four kinds when the block is elaborated: input, output, output with tristate enable, or bidirectional. Every wire that a pad of that kind carries passes through two multiplexers. One sits on the pad side and one on the core side. Each of the two sides has its own scan cell.

With the scan mode input low, the block is transparent. Every core signal reaches its pad and every pad input reaches its core, with no clocked element in between. With scan mode high, the pad-side wires and the core-side wires are both taken over by update latches. Levels arriving at a pad and values driven by a core can be captured into separate scan stages. A test can therefore tell a broken pad from a broken peripheral. A clock that arrives on an ordinary pad is declared as an input pad, so it goes through the same insertion path as its data.

The shift, capture, update and mode controls come from an external test access port controller and are plain level inputs sampled on the rising edge of the test clock. Serial data has no back-pressure: one bit moves per test clock edge while shift is high.

Top module: `bscan_chain`

## Requirements
- R1: Pad kind codes are 0 input, 1 output, 2 tristate output, 3 bidirectional; pad i takes bits [2i+1:2i] of PAD_KINDS. Wires a kind lacks are held constant: core_i is 0 for pads with no input, pad_o is 0 and pad_oe is 0 for input pads, and pad_oe is 1 for output-only pads.
- R2: With scan_mode low, core_i equals pad_i, pad_o equals core_o, and for tristate and bidirectional pads pad_oe equals core_oe, all combinationally.
- R3: Chain position 0 is next to tdi and the last position drives tdo. Pads follow in index order. Within a pad the cells follow the order: input pad-side, input core-side, output core-side, output pad-side, enable core-side, enable pad-side, skipping wires the kind lacks. With the default four pads (input, output, tristate, bidirectional) the chain is 14 cells long.
- R4: On a rising tck edge with shift_en high and capture_en low, every stage takes the value of its neighbour nearer tdi, and stage 0 takes tdi; tdo shows the last stage at all times.
- R5: On a rising tck edge with capture_en high, each observing cell loads its wire (pad_i for input pad-side cells, core_o for output core-side cells, core_oe for enable core-side cells), and each driving cell loads the current value of its own update latch. Capture takes precedence over shift.
- R6: Update latches load from their stages only on a rising tck edge with update_en high; shifting and capturing leave the scan-mode outputs unchanged.
- R7: With scan_mode high, core_i comes from the input core-side latch and pad_o from the output pad-side latch, regardless of pad_i and core_o, so pad and core sides are driven independently.
- R8: With scan_mode high, a tristate or bidirectional pad takes pad_oe from its enable pad-side latch; a latch holding 0 releases the pad (pad_oe low).
- R9: While trst_n is low, all stages and latches are cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| scan_mode | input | 1 | 1 selects the scan latches, 0 passes core and pad straight through |
| capture_en | input | 1 | Load stages from observed wires |
| shift_en | input | 1 | Move the chain one place toward tdo |
| update_en | input | 1 | Copy stages into update latches |
| tdi | input | 1 | Serial data into chain position 0 |
| tdo | output | 1 | Serial data from the last chain position |
| core_o | input | NUM_PADS | Output values from the cores |
| core_oe | input | NUM_PADS | Output enables from the cores |
| core_i | output | NUM_PADS | Input values delivered to the cores |
| pad_i | input | NUM_PADS | Levels received from the pads |
| pad_o | output | NUM_PADS | Values driven toward the pads |
| pad_oe | output | NUM_PADS | Pad output enables |

## Verification
Pass-through is exercised with three unrelated sets of pad inputs, core outputs and enables. This separates a real direct connection from a connection that has been swapped or masked for the wrong pad kind. A distinct serial word is pushed through the full chain and read back, which exposes a wrong order or length. Two capture patterns with opposite polarities on pad_i, core_o and core_oe, taken over different latch contents, show that the pad side and the core side land in separate bits and that driving cells keep their latched value. A loaded drive word is checked before and after the update pulse. This shows the outputs stay still during shifting, that the core and pad sides are driven from separate latches, and that a zero enable latch releases the pad.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    PK_INPUT    = 2'd0,
    PK_OUTPUT   = 2'd1,
    PK_TRISTATE = 2'd2,
    PK_BIDIR    = 2'd3
  } pad_kind_e;

  function automatic bit kind_has_input(pad_kind_e k);
    return (k == PK_INPUT) || (k == PK_BIDIR);
  endfunction

  function automatic bit kind_has_output(pad_kind_e k);
    return k != PK_INPUT;
  endfunction

  function automatic bit kind_has_enable(pad_kind_e k);
    return (k == PK_TRISTATE) || (k == PK_BIDIR);
  endfunction

  // two cells (pad side and core side) per intercepted wire
  function automatic int kind_cells(pad_kind_e k);
    return 2 * (int'(kind_has_input(k)) + int'(kind_has_output(k)) +
                int'(kind_has_enable(k)));
  endfunction

endpackage

// File: rtl/scan_observe_cell.sv
module scan_observe_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic obs_d,
  input  logic ser_d,
  output logic stage_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         stage_q <= 1'b0;
    else if (capture_en) stage_q <= obs_d;
    else if (shift_en)   stage_q <= ser_d;
  end

  AST_OBS_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    capture_en |=> stage_q == $past(obs_d)) else $error("observe capture"); // R5

  AST_OBS_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !capture_en) |=> stage_q == $past(ser_d)) else $error("observe shift"); // R4

  always @(posedge tck) begin
    if (!trst_n) begin
      AST_OBS_RESET: assert (stage_q == 1'b0) else $error("observe reset"); // R9
    end
  end

endmodule

// File: rtl/scan_drive_cell.sv
module scan_drive_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_d,
  output logic stage_q,
  output logic upd_q
);

  // capture reloads the driven value so a read-back shows what is applied
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         stage_q <= 1'b0;
    else if (capture_en) stage_q <= upd_q;
    else if (shift_en)   stage_q <= ser_d;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        upd_q <= 1'b0;
    else if (update_en) upd_q <= stage_q;
  end

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !update_en |=> $stable(upd_q)) else $error("latch moved"); // R6

  AST_LATCH_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    update_en |=> upd_q == $past(stage_q)) else $error("latch load"); // R6

  AST_DRV_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !capture_en) |=> stage_q == $past(ser_d)) else $error("drive shift"); // R4

  always @(posedge tck) begin
    if (!trst_n) begin
      AST_DRV_RESET: assert (stage_q == 1'b0 && upd_q == 1'b0) else $error("drive reset"); // R9
    end
  end

endmodule

// File: rtl/bscan_pad.sv
module bscan_pad
  import bscan_pkg::*;
#(
  parameter pad_kind_e KIND = PK_BIDIR
) (
  input  logic tck,
  input  logic trst_n,
  input  logic scan_mode,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_in,
  output logic ser_out,
  input  logic core_o,
  input  logic core_oe,
  output logic core_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe
);

  localparam bit HAS_IN  = kind_has_input(KIND);
  localparam bit HAS_OUT = kind_has_output(KIND);
  localparam bit HAS_OE  = kind_has_enable(KIND);
  localparam int NCELL   = kind_cells(KIND);

  localparam int P_IN_OBS  = 0;
  localparam int P_IN_DRV  = 1;
  localparam int P_OUT_OBS = HAS_IN ? 2 : 0;
  localparam int P_OUT_DRV = P_OUT_OBS + 1;
  localparam int P_OE_OBS  = P_OUT_OBS + 2;
  localparam int P_OE_DRV  = P_OE_OBS + 1;

  logic [NCELL-1:0] st;
  logic             out_ser;

  assign ser_out = st[NCELL-1];

  generate
    if (HAS_IN) begin : g_in
      logic in_latch;

      scan_observe_cell u_obs (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .obs_d(pad_i), .ser_d(ser_in), .stage_q(st[P_IN_OBS])
      );
      scan_drive_cell u_drv (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .ser_d(st[P_IN_OBS]), .stage_q(st[P_IN_DRV]),
        .upd_q(in_latch)
      );

      assign core_i  = scan_mode ? in_latch : pad_i;
      assign out_ser = st[P_IN_DRV];
    end else begin : g_no_in
      assign core_i  = 1'b0;
      assign out_ser = ser_in;
    end

    if (HAS_OUT) begin : g_out
      logic out_latch;

      scan_observe_cell u_obs (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .obs_d(core_o), .ser_d(out_ser), .stage_q(st[P_OUT_OBS])
      );
      scan_drive_cell u_drv (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .ser_d(st[P_OUT_OBS]), .stage_q(st[P_OUT_DRV]),
        .upd_q(out_latch)
      );

      assign pad_o = scan_mode ? out_latch : core_o;

      AST_SCAN_OUT_STILL: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_mode && $past(scan_mode) && !$past(update_en)) |-> $stable(pad_o))
        else $error("pad output moved without update"); // R6
    end else begin : g_no_out
      assign pad_o = 1'b0;
    end

    if (HAS_OE) begin : g_oe
      logic oe_latch;

      scan_observe_cell u_obs (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .obs_d(core_oe), .ser_d(st[P_OUT_DRV]), .stage_q(st[P_OE_OBS])
      );
      scan_drive_cell u_drv (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .ser_d(st[P_OE_OBS]), .stage_q(st[P_OE_DRV]),
        .upd_q(oe_latch)
      );

      assign pad_oe = scan_mode ? oe_latch : core_oe;

      AST_SCAN_OE_STILL: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_mode && $past(scan_mode) && !$past(update_en)) |-> $stable(pad_oe))
        else $error("pad enable moved without update"); // R8
    end else begin : g_no_oe
      assign pad_oe = HAS_OUT;
    end
  endgenerate

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_KINDS = {PK_BIDIR, PK_TRISTATE, PK_OUTPUT, PK_INPUT}
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                scan_mode,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] core_o,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_i,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] pad_oe
);

  localparam int LINKS = NUM_PADS + 1;

  logic [LINKS-1:0] link;

  assign link[0] = tdi;
  assign tdo     = link[LINKS-1];

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      bscan_pad #(
        .KIND(pad_kind_e'(PAD_KINDS[2*i +: 2]))
      ) u_pad (
        .tck       (tck),
        .trst_n    (trst_n),
        .scan_mode (scan_mode),
        .capture_en(capture_en),
        .shift_en  (shift_en),
        .update_en (update_en),
        .ser_in    (link[i]),
        .ser_out   (link[i+1]),
        .core_o    (core_o[i]),
        .core_oe   (core_oe[i]),
        .core_i    (core_i[i]),
        .pad_i     (pad_i[i]),
        .pad_o     (pad_o[i]),
        .pad_oe    (pad_oe[i])
      );
    end
  endgenerate

endmodule

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

  localparam int NP  = 4;
  localparam int LEN = 14;
  // default kinds: pad0 input, pad1 output, pad2 tristate, pad3 bidirectional (R1)
  localparam logic [NP-1:0] IN_MASK   = 4'b1001;
  localparam logic [NP-1:0] OUT_MASK  = 4'b1110;
  localparam logic [NP-1:0] OE_MASK   = 4'b1100;
  localparam logic [NP-1:0] ONLY_OUT  = 4'b0010;

  logic tck = 1'b0;
  logic trst_n, scan_mode, capture_en, shift_en, update_en, tdi, tdo;
  logic [NP-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 tck = ~tck;

  bscan_chain uut (
    .tck(tck), .trst_n(trst_n), .scan_mode(scan_mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
    .core_o(core_o), .core_oe(core_oe), .core_i(core_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // loads v into the chain (bit p lands at position p) and returns the old contents
  task automatic shift_vec(input logic [LEN-1:0] v, output logic [LEN-1:0] got);
    for (int k = 0; k < LEN; k++) begin
      @(negedge tck);
      got[LEN-1-k] = tdo;
      tdi      = v[LEN-1-k];
      shift_en = 1'b1;
    end
    @(negedge tck);
    shift_en = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge tck); capture_en = 1'b1;
    @(negedge tck); capture_en = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_en = 1'b1;
    @(negedge tck); update_en = 1'b0;
  endtask

  task automatic test_reset();
    trst_n = 1'b0; scan_mode = 1'b1; capture_en = 1'b0; shift_en = 1'b0;
    update_en = 1'b0; tdi = 1'b0; core_o = '1; core_oe = '1; pad_i = '1;
    repeat (3) @(negedge tck);
    check("R9 core_i in reset", 16'(core_i), 16'h0);
    check("R9 pad_o in reset", 16'(pad_o), 16'h0);
    check("R1 R9 pad_oe in reset", 16'(pad_oe), 16'(ONLY_OUT));
    trst_n = 1'b1;
    @(negedge tck);
  endtask

  task automatic test_functional(input logic [NP-1:0] pi, input logic [NP-1:0] co,
                                 input logic [NP-1:0] ce);
    scan_mode = 1'b0; pad_i = pi; core_o = co; core_oe = ce;
    #2;
    check("R2 R1 core_i pass", 16'(core_i), 16'(pi & IN_MASK));
    check("R2 R1 pad_o pass", 16'(pad_o), 16'(co & OUT_MASK));
    check("R2 R1 pad_oe pass", 16'(pad_oe), 16'((ce & OE_MASK) | ONLY_OUT));
  endtask

  task automatic test_shift_through();
    logic [LEN-1:0] got;
    scan_mode = 1'b1;
    shift_vec(14'h2D3C, got);
    check("R9 chain empty after reset", 16'(got), 16'h0);
    shift_vec(14'h0000, got);
    check("R3 R4 word read back", 16'(got), 16'h2D3C);
  endtask

  task automatic test_capture_zero_latch();
    logic [LEN-1:0] got;
    scan_mode = 1'b1;
    pad_i = 4'b1001; core_o = 4'b1010; core_oe = 4'b0100;
    pulse_capture();
    #2;
    check("R7 core_i held by latch while pad high", 16'(core_i), 16'h0);
    shift_vec(14'h0000, got);
    check("R5 R3 capture with cleared latches", 16'(got), 16'h0545);
  endtask

  task automatic test_drive();
    logic [LEN-1:0] got;
    scan_mode = 1'b1;
    pad_i = 4'b0000; core_o = 4'b1111; core_oe = 4'b1111;
    shift_vec(14'h088B, got);
    check("R6 core_i still before update", 16'(core_i), 16'h0);
    check("R6 pad_o still before update", 16'(pad_o), 16'h0);
    check("R6 pad_oe still before update", 16'(pad_oe), 16'(ONLY_OUT));
    pulse_update();
    #2;
    check("R7 core_i from latches", 16'(core_i), 16'b0001);
    check("R7 pad_o from latches", 16'(pad_o), 16'b1010);
    check("R8 pad_oe from latches, pad3 released", 16'(pad_oe), 16'b0110);
  endtask

  task automatic test_capture_loaded_latch();
    logic [LEN-1:0] got;
    scan_mode = 1'b1;
    pad_i = 4'b0110; core_o = 4'b0101; core_oe = 4'b1000;
    pulse_capture();
    shift_vec(14'h0000, got);
    check("R5 capture with loaded latches", 16'(got), 16'h189A);
    #2;
    check("R6 outputs unchanged by capture and shift", 16'(pad_o), 16'b1010);
  endtask

  initial begin
    test_reset();
    test_functional(4'b1001, 4'b0110, 4'b1100);
    test_functional(4'b0110, 4'b1001, 4'b0011);
    test_functional(4'b1111, 4'b1111, 4'b1111);
    test_shift_through();
    test_capture_zero_latch();
    test_drive();
    test_capture_loaded_latch();
    test_functional(4'b1000, 4'b0100, 4'b0100);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule